// File: doc/BRIEF.md
# Cascaded Loadable Range Counter

This block is a synchronous wide counter built from identical narrow counter slices on one clock. Each slice has a synchronous clear, a parallel load and a count enable. The enable passes along the chain, so a slice advances only when every slice below it is at its all-ones value. The result is a plain binary count across the full width.

A mode input can also shorten the sequence of the lowest slice. In decade mode the low slice is cleared when it reaches its end value. In offset mode the low slice is reloaded with a start value when it reaches its end value. In both shortened modes the upper slices are cleared on each enabled edge. A combinational terminal-count output flags the last state of the active sequence, so a following stage can be enabled from it.

Top module: `range_cnt_top`

## Requirements
- R1: A high `rst` sampled at a rising clock edge sets `count` to 0 at that edge, whatever `en` and `mode` are.
- R2: With `rst` low and `en` low, `count` keeps its value across the edge in every mode.
- R3: Binary mode (`mode` = 2'b00, and also 2'b11) adds 1 to `count` on each enabled edge. The upper nibble advances only when the lower nibble is 4'b1111, and 255 rolls over to 0.
- R4: Decade mode (`mode` = 2'b01) takes the low nibble from 9 to 0 on an enabled edge. Otherwise it adds 1, giving the period 0,1,...,9.
- R5: Offset mode (`mode` = 2'b10) loads 6 into the low nibble on an enabled edge when it holds 14. Otherwise it adds 1, giving the period 6,...,14 (nine states).
- R6: In decade and offset modes, an enabled edge sets the upper nibble of `count` to 0.
- R7: `tc` is combinational and ignores `rst`. It is 1 exactly when `en` is 1 and the count is at the end of the active sequence: 255 in binary mode, a low nibble of 9 in decade mode, and a low nibble of 14 in offset mode.
- R8: In a shortened mode, a low nibble outside the normal sequence adds 1 on each enabled edge and wraps from 15 to 0. A low nibble below the start value counts up until it joins the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all slices |
| rst | input | 1 | Synchronous clear, active high, highest priority |
| en | input | 1 | Count enable |
| mode | input | 2 | 00/11 binary, 01 decade, 10 offset |
| count | output | 8 | Current count, all slices concatenated |
| tc | output | 1 | Terminal count of the active sequence |

## Verification
On every cycle, the checker confirms the clear after reset and the hold when disabled. It also confirms the step by one in binary mode, the decade and offset wrap points, the clearing of the upper nibble, and the rollover after a terminal count. Only the bench's scenarios can show the full periods of each mode: the whole 256-state binary run, the 0-to-9 and 6-to-14 periods, and values outside the sequence rejoining it after a mode change.

// File: rtl/range_cnt_pkg.sv
package range_cnt_pkg;
   typedef enum logic [1:0] {
      CM_BIN     = 2'b00,
      CM_DEC     = 2'b01,
      CM_OFS     = 2'b10,
      CM_BIN_ALT = 2'b11
   } cnt_mode_e;
endpackage

// File: rtl/cnt_slice.sv
module cnt_slice #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         clr,
   input  logic         ld,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         full
);
   always_ff @(posedge clk) begin
      if (clr)     q <= '0;
      else if (ld) q <= d;
      else if (en) q <= q + 1'b1;
   end

   assign full = &q;
endmodule

// File: rtl/cnt_mod_ctrl.sv
module cnt_mod_ctrl
   import range_cnt_pkg::*;
#(
   parameter int W         = 4,
   parameter int DEC_END   = 9,
   parameter int OFS_START = 6,
   parameter int OFS_END   = 14
) (
   input  logic         rst,
   input  logic         en,
   input  cnt_mode_e    mode,
   input  logic [W-1:0] low_q,
   input  logic         wide_full,
   output logic         low_clr,
   output logic         low_ld,
   output logic [W-1:0] low_d,
   output logic         hi_clr,
   output logic         tc
);
   localparam logic [W-1:0] DEC_END_V   = W'(DEC_END);
   localparam logic [W-1:0] OFS_START_V = W'(OFS_START);
   localparam logic [W-1:0] OFS_END_V   = W'(OFS_END);

   logic         is_dec, is_ofs, trunc;
   logic [W-1:0] end_val;
   logic         at_end;

   always_comb begin
      is_dec  = (mode == CM_DEC);
      is_ofs  = (mode == CM_OFS);
      trunc   = is_dec | is_ofs;
      end_val = is_dec ? DEC_END_V : OFS_END_V;
      at_end  = (low_q == end_val);
      low_clr = rst | (en & is_dec & at_end);
      low_ld  = en & is_ofs & at_end;
      low_d   = OFS_START_V;
      hi_clr  = rst | (en & trunc);
      tc      = en & (trunc ? at_end : wide_full);
   end
endmodule

// File: rtl/range_cnt_top.sv
module range_cnt_top
   import range_cnt_pkg::*;
#(
   parameter int SLICE_W   = 4,
   parameter int NSLICE    = 2,
   parameter int DEC_END   = 9,
   parameter int OFS_START = 6,
   parameter int OFS_END   = 14
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      en,
   input  logic [1:0]                mode,
   output logic [SLICE_W*NSLICE-1:0] count,
   output logic                      tc
);
   localparam int CNT_W = SLICE_W * NSLICE;
   localparam int S_MAX = (1 << SLICE_W) - 1;

   if (SLICE_W < 2) begin : g_bad_w
      $error("SLICE_W must be at least 2");
   end
   if (NSLICE < 1) begin : g_bad_n
      $error("NSLICE must be at least 1");
   end
   if (DEC_END < 1 || DEC_END > S_MAX) begin : g_bad_dec
      $error("DEC_END outside slice range");
   end
   if (OFS_START >= OFS_END || OFS_END > S_MAX) begin : g_bad_ofs
      $error("offset window invalid");
   end

   cnt_mode_e          mode_e;
   logic [NSLICE:0]    en_chain;
   logic [NSLICE-1:0]  full;
   logic               low_clr, low_ld, hi_clr;
   logic [SLICE_W-1:0] low_d;

   assign mode_e      = cnt_mode_e'(mode);
   assign en_chain[0] = en;

   cnt_mod_ctrl #(
      .W(SLICE_W), .DEC_END(DEC_END),
      .OFS_START(OFS_START), .OFS_END(OFS_END)
   ) u_ctrl (
      .rst      (rst),
      .en       (en),
      .mode     (mode_e),
      .low_q    (count[SLICE_W-1:0]),
      .wide_full(&full),
      .low_clr  (low_clr),
      .low_ld   (low_ld),
      .low_d    (low_d),
      .hi_clr   (hi_clr),
      .tc       (tc)
   );

   for (genvar i = 0; i < NSLICE; i++) begin : g_slice
      logic               s_clr, s_ld;
      logic [SLICE_W-1:0] s_d;
      if (i == 0) begin : g_low
         assign s_clr = low_clr;
         assign s_ld  = low_ld;
         assign s_d   = low_d;
      end else begin : g_high
         assign s_clr = hi_clr;
         assign s_ld  = 1'b0;
         assign s_d   = '0;
      end
      cnt_slice #(.W(SLICE_W)) u_slice (
         .clk (clk),
         .clr (s_clr),
         .ld  (s_ld),
         .en  (en_chain[i]),
         .d   (s_d),
         .q   (count[i*SLICE_W +: SLICE_W]),
         .full(full[i])
      );
      assign en_chain[i+1] = en_chain[i] & full[i];
   end
endmodule

// File: rtl/range_cnt_chk.sv
module range_cnt_chk #(
   parameter int SLICE_W   = 4,
   parameter int CNT_W     = 8,
   parameter int DEC_END   = 9,
   parameter int OFS_START = 6,
   parameter int OFS_END   = 14
) (
   input logic             clk,
   input logic             rst,
   input logic             en,
   input logic [1:0]       mode,
   input logic [CNT_W-1:0] count,
   input logic             tc
);
   logic bin_m, trunc_m;
   assign bin_m   = (mode == 2'b00) || (mode == 2'b11);
   assign trunc_m = (mode == 2'b01) || (mode == 2'b10);

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> count == '0);  // R1
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(count));  // R2
   AST_BIN_STEP: assert property (@(posedge clk) disable iff (rst)
      en && bin_m |=> count == CNT_W'($past(count) + 1'b1));  // R3
   AST_DEC_WRAP: assert property (@(posedge clk) disable iff (rst)
      en && mode == 2'b01 && count[SLICE_W-1:0] == SLICE_W'(DEC_END)
      |=> count[SLICE_W-1:0] == '0);  // R4
   AST_OFS_WRAP: assert property (@(posedge clk) disable iff (rst)
      en && mode == 2'b10 && count[SLICE_W-1:0] == SLICE_W'(OFS_END)
      |=> count[SLICE_W-1:0] == SLICE_W'(OFS_START));  // R5
   AST_HIGH_CLEAR: assert property (@(posedge clk) disable iff (rst)
      en && trunc_m |=> count[CNT_W-1:SLICE_W] == '0);  // R6
   AST_TC_ROLL: assert property (@(posedge clk) disable iff (rst)
      tc && bin_m |=> count == '0);  // R7
   AST_TC_NEEDS_EN: assert property (@(posedge clk)
      tc |-> en);  // R7
endmodule

bind range_cnt_top range_cnt_chk #(
   .SLICE_W(SLICE_W), .CNT_W(CNT_W), .DEC_END(DEC_END),
   .OFS_START(OFS_START), .OFS_END(OFS_END)
) u_chk (
   .clk(clk), .rst(rst), .en(en), .mode(mode), .count(count), .tc(tc)
);

// File: tb/test_range_cnt_top.sv
module test_range_cnt_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en  = 1'b0;
   logic [1:0] mode = 2'b00;
   logic [7:0] count;
   logic       tc;
   int         n_cmp = 0;
   int         n_bad = 0;
   bit         done  = 1'b0;
   logic [7:0] model = 8'd0;

   always #10 clk = ~clk;

   range_cnt_top i_range_cnt_top (
      .clk(clk), .rst(rst), .en(en), .mode(mode), .count(count), .tc(tc)
   );

   // {rst, en, mode[1:0], expected count after the edge}
   localparam int NV = 16;
   localparam logic [11:0] VEC [NV] = '{
      {1'b1, 1'b1, 2'b00, 8'd0},   // R1
      {1'b0, 1'b1, 2'b00, 8'd1},   // R3
      {1'b0, 1'b1, 2'b00, 8'd2},
      {1'b0, 1'b0, 2'b00, 8'd2},   // R2
      {1'b0, 1'b1, 2'b01, 8'd3},
      {1'b0, 1'b1, 2'b01, 8'd4},
      {1'b0, 1'b1, 2'b01, 8'd5},
      {1'b0, 1'b1, 2'b01, 8'd6},
      {1'b0, 1'b1, 2'b01, 8'd7},
      {1'b0, 1'b1, 2'b01, 8'd8},
      {1'b0, 1'b1, 2'b01, 8'd9},
      {1'b0, 1'b1, 2'b01, 8'd0},   // R4
      {1'b0, 1'b0, 2'b10, 8'd0},   // R2
      {1'b0, 1'b1, 2'b10, 8'd1},   // R8
      {1'b0, 1'b1, 2'b11, 8'd2},   // R3 alt code
      {1'b1, 1'b0, 2'b10, 8'd0}    // R1
   };

   function automatic logic [7:0] nxt(logic [7:0] c, logic r, logic e, logic [1:0] m);
      logic [3:0] lo;
      lo = c[3:0];
      if (r) return 8'd0;
      if (!e) return c;
      if (m == 2'b01) return {4'd0, (lo == 4'd9) ? 4'd0 : lo + 4'd1};
      if (m == 2'b10) return {4'd0, (lo == 4'd14) ? 4'd6 : lo + 4'd1};
      return c + 8'd1;
   endfunction

   function automatic logic tc_of(logic [7:0] c, logic e, logic [1:0] m);
      if (!e) return 1'b0;
      if (m == 2'b01) return c[3:0] == 4'd9;
      if (m == 2'b10) return c[3:0] == 4'd14;
      return c == 8'd255;
   endfunction

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Drive at negedge, check tc combinationally, then check count after the edge.
   task automatic step(string tag, logic r, logic e, logic [1:0] m);
      @(negedge clk);
      rst = r; en = e; mode = m;
      #1;
      check({tag, " R7 tc"}, {7'd0, tc}, {7'd0, tc_of(model, e, m)});
      @(posedge clk);
      model = nxt(model, r, e, m);
      #1;
      check(tag, count, model);
   endtask

   initial begin
      repeat (2) @(posedge clk);
      #1;
      check("R1 reset state", count, 8'd0);
      model = 8'd0;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         rst = VEC[i][11]; en = VEC[i][10]; mode = VEC[i][9:8];
         @(posedge clk);
         #1;
         check("R1/R2/R3/R4 vector", count, VEC[i][7:0]);
      end
      model = 8'd0;

      // R3: one full binary period with 255 -> 0 rollover
      for (int i = 0; i < 256; i++) step("R3 binary period", 1'b0, 1'b1, 2'b00);
      check("R3 rollover end", count, 8'd0);

      // R1: reset beats enable from a mid value
      for (int i = 0; i < 40; i++) step("R3 advance", 1'b0, 1'b1, 2'b00);
      step("R1 reset priority", 1'b1, 1'b1, 2'b10);

      // R4: decade period twice
      for (int i = 0; i < 20; i++) step("R4 decade period", 1'b0, 1'b1, 2'b01);

      // R5/R8: offset mode from 0 climbs to 6 then period of nine
      step("R1 clear", 1'b1, 1'b0, 2'b00);
      for (int i = 0; i < 24; i++) step("R5/R8 offset period", 1'b0, 1'b1, 2'b10);

      // R2: hold in offset mode
      for (int i = 0; i < 3; i++) step("R2 hold offset", 1'b0, 1'b0, 2'b10);

      // R6/R8: binary to 0xAC, then decade clears high nibble and wraps 15 -> 0
      step("R1 clear", 1'b1, 1'b0, 2'b00);
      for (int i = 0; i < 172; i++) step("R3 advance", 1'b0, 1'b1, 2'b00);
      check("R3 reached 0xAC", count, 8'hAC);
      step("R2 hold high nibble", 1'b0, 1'b0, 2'b01);
      step("R6 high nibble cleared", 1'b0, 1'b1, 2'b01);
      check("R6 value 0x0D", count, 8'h0D);
      for (int i = 0; i < 4; i++) step("R8 out of range decade", 1'b0, 1'b1, 2'b01);
      check("R8 wrapped to 1", count, 8'd1);

      // R8: offset mode from 15 wraps to 0
      step("R1 clear", 1'b1, 1'b0, 2'b00);
      for (int i = 0; i < 15; i++) step("R3 advance", 1'b0, 1'b1, 2'b00);
      step("R8 offset from 15", 1'b0, 1'b1, 2'b10);
      check("R8 offset wrap value", count, 8'd0);

      // R7: tc ignores reset
      @(negedge clk);
      rst = 1'b1; en = 1'b1; mode = 2'b01;
      #1;
      check("R7 tc low at count 0 under reset", {7'd0, tc}, 8'd0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule